// File: doc/BRIEF.md
# Instruction-Boundary Exception Checker

This block sits in the control path of a microprogrammed processor and is consulted once per macroinstruction, just before the next fetch. The sequencer raises a one-cycle boundary strobe. The checker then looks at five pending exceptional conditions and decides whether the ordinary fetch proceeds or one service routine is entered instead. The five conditions are a trace trap, an interrupt request, a console halt, a program counter at an odd address, and a stack push below the stack floor. The decision is registered and shown on the outputs for exactly one cycle. It comes as a fetch strobe, or as a service-valid strobe with a one-hot vector and a binary code that select the routine.

Two controls shape the checks. A fast-mode switch drops the odd-PC test and the stack-floor test, so code already known to be well behaved spends no time on them. A return-from-trace event arms a one-shot mask that hides the trace trap at the next boundary. An ordinary interrupt return leaves that mask alone.

Top module: `boundary_exc_check`

## Requirements
- R1: While and right after synchronous reset, fetch_go, svc_valid, svc_onehot and svc_code are all zero.
- R2: A boundary_valid seen at a rising edge produces, in the following cycle only, exactly one of fetch_go or svc_valid high; in cycles not following a boundary both are low.
- R3: Priority from highest to lowest is trace (onehot bit 0, code 0), interrupt (bit 1, code 1), halt (bit 2, code 2), odd PC (bit 3, code 3), stack floor (bit 4, code 4); only the highest pending condition's bit is set, and svc_code equals its index.
- R4: When no condition holds at a boundary, fetch_go pulses and svc_onehot is zero.
- R5: The odd-PC condition is pc_value bit 0 equal to 1.
- R6: The stack-floor condition is push_active high together with sp_value below 16'h0100 (16'h00FF triggers, 16'h0100 does not, no push never triggers).
- R7: With fast_mode high at the boundary, the odd-PC and stack-floor conditions are ignored while trace, interrupt and halt still apply.
- R8: A ret_done pulse with ret_trace=1 masks trace_pending at the next boundary only; that boundary consumes the mask.
- R9: A ret_done pulse with ret_trace=0 leaves trace checking unchanged at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_valid | input | 1 | One-cycle strobe marking an instruction boundary |
| trace_pending | input | 1 | Trace trap pending |
| irq_req | input | 1 | Interrupt request |
| halt_req | input | 1 | Console halt request |
| pc_value | input | 16 | Current program counter |
| sp_value | input | 16 | Current stack pointer |
| push_active | input | 1 | A stack push is in progress |
| fast_mode | input | 1 | Skip odd-PC and stack-floor checks |
| ret_done | input | 1 | A return instruction has completed |
| ret_trace | input | 1 | Qualifies ret_done: 1 = return-from-trace, 0 = interrupt return |
| fetch_go | output | 1 | Proceed with normal fetch (one cycle) |
| svc_valid | output | 1 | A service routine is selected (one cycle) |
| svc_onehot | output | 5 | One-hot routine select |
| svc_code | output | 3 | Encoded routine select |

## Verification
The hardest situation to reach is a boundary where the trace mask is armed while other conditions are pending. Only then does masking the trace trap change which routine wins. The stimulus gets there with directed sequences of a trace-return pulse followed by a boundary carrying trace together with an interrupt, a halt or nothing else. The random phase then mixes both kinds of return pulse with random condition sets between boundaries, and the bench model tracks the armed state itself. The stack-floor edges at 16'h00FF and 16'h0100 are also forced directly, because random stack pointers rarely land on them.

// File: rtl/bchk_pkg.sv
package bchk_pkg;

    localparam int NUM_COND = 5;
    localparam int CODE_W   = $clog2(NUM_COND);

    typedef enum logic [CODE_W-1:0] {
        CAUSE_TRACE = 3'd0,
        CAUSE_IRQ   = 3'd1,
        CAUSE_HALT  = 3'd2,
        CAUSE_ODDPC = 3'd3,
        CAUSE_STACK = 3'd4
    } cause_e;

    // Bit order equals priority order: bit 0 is checked first.
    typedef struct packed {
        logic stack_ovf;
        logic odd_pc;
        logic halt;
        logic irq;
        logic trace;
    } cond_vec_t;

    typedef struct packed {
        logic                fetch_go;
        logic                svc_valid;
        logic [NUM_COND-1:0] onehot;
        logic [CODE_W-1:0]   code;
    } verdict_t;

    function automatic logic [CODE_W-1:0] onehot_to_code(input logic [NUM_COND-1:0] oh);
        logic [CODE_W-1:0] c;
        c = '0;
        for (int i = 0; i < NUM_COND; i++) begin
            if (oh[i]) c = CODE_W'(i);
        end
        return c;
    endfunction

endpackage

// File: rtl/cond_capture.sv
module cond_capture
    import bchk_pkg::*;
#(
    parameter int                WORD_W      = 16,
    parameter logic [WORD_W-1:0] STACK_FLOOR = 16'h0100
) (
    input  logic              trace_pending,
    input  logic              trace_masked,
    input  logic              irq_req,
    input  logic              halt_req,
    input  logic [WORD_W-1:0] pc_value,
    input  logic [WORD_W-1:0] sp_value,
    input  logic              push_active,
    input  logic              fast_mode,
    output cond_vec_t         cond
);
    logic unused_pc_hi;
    logic odd_raw;
    logic floor_raw;

    assign unused_pc_hi = ^pc_value[WORD_W-1:1];
    assign odd_raw      = pc_value[0];
    assign floor_raw    = push_active && (sp_value < STACK_FLOOR);

    always_comb begin
        cond           = '0;
        cond.trace     = trace_pending && !trace_masked;
        cond.irq       = irq_req;
        cond.halt      = halt_req;
        cond.odd_pc    = odd_raw && !fast_mode;
        cond.stack_ovf = floor_raw && !fast_mode;
    end
endmodule

// File: rtl/prio_select.sv
module prio_select #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N-1:0] blocked;

    for (genvar i = 0; i < N; i++) begin : g_chain
        if (i == 0) begin : g_head
            assign blocked[i] = 1'b0;
        end else begin : g_link
            assign blocked[i] = blocked[i-1] | req[i-1];
        end
        assign grant[i] = req[i] & ~blocked[i];
    end

    assign any = |req;
endmodule

// File: rtl/trace_suppress.sv
module trace_suppress (
    input  logic clk,
    input  logic rst,
    input  logic ret_done,
    input  logic ret_trace,
    input  logic boundary_valid,
    output logic trace_masked
);
    logic arm;
    assign arm = ret_done && ret_trace;

    always_ff @(posedge clk) begin
        if (rst)                 trace_masked <= 1'b0;
        else if (arm)            trace_masked <= 1'b1;
        else if (boundary_valid) trace_masked <= 1'b0;
    end

    p_arm_r8: assert property (@(posedge clk) disable iff (rst)
        arm |=> trace_masked);
    p_consume_r8: assert property (@(posedge clk) disable iff (rst)
        (boundary_valid && !arm) |=> !trace_masked);
    p_rti_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (ret_done && !ret_trace && !boundary_valid) |=> $stable(trace_masked));
endmodule

// File: rtl/boundary_exc_check.sv
module boundary_exc_check
    import bchk_pkg::*;
#(
    parameter int                WORD_W      = 16,
    parameter logic [WORD_W-1:0] STACK_FLOOR = 16'h0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary_valid,
    input  logic              trace_pending,
    input  logic              irq_req,
    input  logic              halt_req,
    input  logic [WORD_W-1:0] pc_value,
    input  logic [WORD_W-1:0] sp_value,
    input  logic              push_active,
    input  logic              fast_mode,
    input  logic              ret_done,
    input  logic              ret_trace,
    output logic              fetch_go,
    output logic              svc_valid,
    output logic [NUM_COND-1:0] svc_onehot,
    output logic [CODE_W-1:0]   svc_code
);
    logic                trace_masked;
    cond_vec_t           cond;
    logic [NUM_COND-1:0] grant;
    logic                any_cond;
    verdict_t            verdict_q;

    trace_suppress u_mask (
        .clk            (clk),
        .rst            (rst),
        .ret_done       (ret_done),
        .ret_trace      (ret_trace),
        .boundary_valid (boundary_valid),
        .trace_masked   (trace_masked)
    );

    cond_capture #(.WORD_W(WORD_W), .STACK_FLOOR(STACK_FLOOR)) u_cond (
        .trace_pending (trace_pending),
        .trace_masked  (trace_masked),
        .irq_req       (irq_req),
        .halt_req      (halt_req),
        .pc_value      (pc_value),
        .sp_value      (sp_value),
        .push_active   (push_active),
        .fast_mode     (fast_mode),
        .cond          (cond)
    );

    prio_select #(.N(NUM_COND)) u_prio (
        .req   (cond),
        .grant (grant),
        .any   (any_cond)
    );

    // Verdict is a one-cycle pulse following each boundary strobe.
    always_ff @(posedge clk) begin
        if (rst || !boundary_valid) begin
            verdict_q <= '0;
        end else begin
            verdict_q.fetch_go  <= !any_cond;
            verdict_q.svc_valid <= any_cond;
            verdict_q.onehot    <= grant;
            verdict_q.code      <= onehot_to_code(grant);
        end
    end

    assign fetch_go   = verdict_q.fetch_go;
    assign svc_valid  = verdict_q.svc_valid;
    assign svc_onehot = verdict_q.onehot;
    assign svc_code   = verdict_q.code;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!fetch_go && !svc_valid && svc_onehot == '0));
    p_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(fetch_go && svc_valid));
    p_answer_r2: assert property (@(posedge clk) disable iff (rst)
        boundary_valid |=> (fetch_go ^ svc_valid));
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !boundary_valid |=> (!fetch_go && !svc_valid));
    p_single_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(svc_onehot));
    p_valid_map_r3: assert property (@(posedge clk) disable iff (rst)
        svc_valid == (svc_onehot != '0));
    p_irq_rank_r3: assert property (@(posedge clk) disable iff (rst)
        (boundary_valid && irq_req) |=> (svc_valid && svc_code <= CAUSE_IRQ));
    p_halt_rank_r3: assert property (@(posedge clk) disable iff (rst)
        (boundary_valid && halt_req) |=> (svc_valid && svc_code <= CAUSE_HALT));
    p_odd_r5: assert property (@(posedge clk) disable iff (rst)
        (boundary_valid && pc_value[0] && !fast_mode) |=> svc_valid);
    p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
        (boundary_valid && fast_mode) |=> (!svc_onehot[3] && !svc_onehot[4]));
endmodule

// File: tb/test_boundary_exc_check.sv
module test_boundary_exc_check;
    logic        clk = 1'b0;
    logic        rst;
    logic        boundary_valid, trace_pending, irq_req, halt_req;
    logic [15:0] pc_value, sp_value;
    logic        push_active, fast_mode, ret_done, ret_trace;
    logic        fetch_go, svc_valid;
    logic [4:0]  svc_onehot;
    logic [2:0]  svc_code;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;
    bit  mask_m   = 0;

    always #10 clk = ~clk;

    boundary_exc_check i_boundary_exc_check (
        .clk(clk), .rst(rst), .boundary_valid(boundary_valid),
        .trace_pending(trace_pending), .irq_req(irq_req), .halt_req(halt_req),
        .pc_value(pc_value), .sp_value(sp_value), .push_active(push_active),
        .fast_mode(fast_mode), .ret_done(ret_done), .ret_trace(ret_trace),
        .fetch_go(fetch_go), .svc_valid(svc_valid),
        .svc_onehot(svc_onehot), .svc_code(svc_code)
    );

    function automatic logic [9:0] model(input bit tr, input bit irq, input bit hlt,
                                         input bit pc0, input logic [15:0] sp,
                                         input bit push, input bit fast, input bit masked);
        logic [4:0] c;
        c[0] = tr && !masked;
        c[1] = irq;
        c[2] = hlt;
        c[3] = pc0 && !fast;
        c[4] = push && (sp < 16'h0100) && !fast;
        for (int i = 0; i < 5; i++)
            if (c[i]) return {1'b0, 1'b1, 5'(1 << i), 3'(i)};
        return {1'b1, 1'b0, 5'b0, 3'b0};
    endfunction

    task automatic check(input string req, input logic [9:0] exp);
        logic [9:0] act;
        act = {fetch_go, svc_valid, svc_onehot, svc_code};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        boundary_valid = 0; trace_pending = 0; irq_req = 0; halt_req = 0;
        pc_value = 16'h1000; sp_value = 16'h2000; push_active = 0;
        fast_mode = 0; ret_done = 0; ret_trace = 0;
    endtask

    task automatic ret_pulse(input bit is_trace);
        ret_done = 1; ret_trace = is_trace;
        @(negedge clk);
        ret_done = 0; ret_trace = 0;
        if (is_trace) mask_m = 1;
    endtask

    task automatic boundary(input string req, input bit tr, input bit irq, input bit hlt,
                            input bit pc0, input logic [15:0] sp, input bit push,
                            input bit fast);
        logic [9:0] exp;
        exp = model(tr, irq, hlt, pc0, sp, push, fast, mask_m);
        boundary_valid = 1; trace_pending = tr; irq_req = irq; halt_req = hlt;
        pc_value = {15'h0800, pc0}; sp_value = sp; push_active = push; fast_mode = fast;
        @(negedge clk);
        clear_inputs();
        mask_m = 0;
        check(req, exp);
        @(negedge clk);
        check("R2", 10'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED_1234));
        clear_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        check("R1", 10'b0);
        rst = 0;
        @(negedge clk);
        check("R1", 10'b0);

        boundary("R4", 0, 0, 0, 0, 16'h2000, 0, 0);
        boundary("R3", 1, 1, 1, 1, 16'h0000, 1, 0);
        boundary("R3", 0, 1, 1, 1, 16'h0000, 1, 0);
        boundary("R3", 0, 0, 1, 1, 16'h0000, 1, 0);
        boundary("R5", 0, 0, 0, 1, 16'h0000, 1, 0);
        boundary("R6", 0, 0, 0, 0, 16'h00FF, 1, 0);
        boundary("R6", 0, 0, 0, 0, 16'h0100, 1, 0);
        boundary("R6", 0, 0, 0, 0, 16'h0000, 0, 0);
        boundary("R7", 0, 0, 0, 1, 16'h0010, 1, 1);
        boundary("R7", 0, 0, 1, 1, 16'h0010, 1, 1);
        boundary("R7", 1, 0, 0, 1, 16'h0010, 1, 1);
        // Trace mask: hides trace for exactly one boundary.
        ret_pulse(1);
        boundary("R8", 1, 0, 0, 0, 16'h2000, 0, 0);
        boundary("R8", 1, 0, 0, 0, 16'h2000, 0, 0);
        ret_pulse(1);
        boundary("R8", 1, 1, 0, 0, 16'h2000, 0, 0);
        ret_pulse(1);
        @(negedge clk);
        boundary("R8", 1, 0, 1, 0, 16'h2000, 0, 0);
        ret_pulse(0);
        boundary("R9", 1, 0, 0, 0, 16'h2000, 0, 0);

        for (int k = 0; k < 400; k++) begin
            int r;
            logic [15:0] sp;
            r = $urandom_range(0, 7);
            if (r == 0) ret_pulse(1);
            else if (r == 1) ret_pulse(0);
            case ($urandom_range(0, 3))
                0: sp = 16'h00FF;
                1: sp = 16'h0100;
                default: sp = 16'($urandom);
            endcase
            boundary("R3",
                     $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
                     $urandom_range(0, 4) == 0, $urandom_range(0, 3) == 0,
                     sp, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
            if ($urandom_range(0, 2) == 0) @(negedge clk);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule